// File: doc/BRIEF.md
# Gated Programmable Clock Output

This block drives a clock onto a general-purpose output pin from a reference clock (nominally 24 MHz). An 8-bit setting picks the rate. A setting of zero sends the reference itself to the pin. A setting N from 1 to 255 produces a 50% duty-cycle clock at the reference rate divided by 2×N. This divider is separate from any UART baud-rate divider and does not interact with one.

The pin carries a clock only while the host has finished configuring the device and the device is not suspended. At all other times the pin sits at a static low. The pin is switched on and off only at a point where the output is already low, so no truncated pulse ever reaches it. A new setting is taken up at the end of the half-period in progress.

Top module: `clkout_gen`

## Requirements
- R1: While reset is held, the pin is low during both phases of the reference clock.
- R2: With a setting of 0 and the output enabled, the pin is high while the reference is high and low while it is low.
- R3: With a setting N in 1..255 and the output enabled, every high phase and every low phase of the pin lasts exactly N reference cycles, so the period is 2×N cycles.
- R4: The output is enabled exactly when host_configured is 1 and host_suspended is 0. Once the last pulse has finished, the pin stays low for as long as the output is disabled.
- R5: When the output is disabled during a high phase, that high phase still lasts its full N cycles before the pin goes low.
- R6: When the output is enabled in divide mode, the first high pulse lasts the full N cycles and begins within 3×N+3 reference cycles.
- R7: A change of setting takes effect at the next half-period boundary. The half-period in progress keeps the old length, and the half-periods after it use the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock, nominally 24 MHz |
| rst | input | 1 | Synchronous active-high reset |
| div_setting | input | DIV_W (8) | Rate setting: 0 = direct, N = reference/(2×N) |
| host_configured | input | 1 | Host has finished configuring the device |
| host_suspended | input | 1 | Device is in the suspend state |
| clk_pin | output | 1 | Gated clock output |

## Verification
A counter that wraps at the wrong value shows up within one half-period as a high or low run whose length is not N. A phase that is held or inverted at a reload shows up as a run of the old length after a setting change. A run flag that changes at the wrong moment produces a shortened first or last high pulse, or activity on the pin after disable; this is visible within about three half-periods. The bench sweeps every setting from 1 to 16, plus 255, measuring each run at the pin, and separately checks the direct mode at both reference phases.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

    typedef enum logic {
        CKM_DIRECT  = 1'b0,
        CKM_DIVIDED = 1'b1
    } clk_mode_e;

    function automatic clk_mode_e mode_from_zero(input logic limit_is_zero);
        return limit_is_zero ? CKM_DIRECT : CKM_DIVIDED;
    endfunction

endpackage

// File: rtl/clkout_divider.sv
module clkout_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_in,
    output logic [DIV_W-1:0] cnt_q,
    output logic [DIV_W-1:0] lim_q,
    output logic             ph_q,
    output logic             fall_wrap
);
    logic wrap;
    logic direct_now;

    always_comb begin
        direct_now = (lim_q == '0);
        wrap       = direct_now || (cnt_q == DIV_W'(lim_q - 1'b1));
        fall_wrap  = wrap && ph_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= '0;
            ph_q  <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            lim_q <= div_in;
            ph_q  <= (div_in != '0) && !direct_now && !ph_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/clkout_gate.sv
module clkout_gate
    import clkout_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      want,
    input  clk_mode_e mode,
    input  logic      fall_wrap,
    output logic      run_q,
    output logic      direct_en_q
);
    always_ff @(posedge clk) begin
        if (rst)
            run_q <= 1'b0;
        else if (mode == CKM_DIRECT || fall_wrap)
            run_q <= want;
    end

    always_ff @(negedge clk) begin
        if (rst)
            direct_en_q <= 1'b0;
        else
            direct_en_q <= run_q && (mode == CKM_DIRECT);
    end
endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
    import clkout_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             ref_clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_setting,
    input  logic             host_configured,
    input  logic             host_suspended,
    output logic             clk_pin
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim_q;
    logic             ph_q;
    logic             fall_wrap;
    logic             run_q;
    logic             direct_en_q;
    logic             want;
    clk_mode_e        mode;

    always_comb begin
        want = host_configured && !host_suspended;
        mode = mode_from_zero(lim_q == '0);
    end

    clkout_divider #(.DIV_W(DIV_W)) i_div (
        .clk       (ref_clk),
        .rst       (rst),
        .div_in    (div_setting),
        .cnt_q     (cnt_q),
        .lim_q     (lim_q),
        .ph_q      (ph_q),
        .fall_wrap (fall_wrap)
    );

    clkout_gate i_gate (
        .clk         (ref_clk),
        .rst         (rst),
        .want        (want),
        .mode        (mode),
        .fall_wrap   (fall_wrap),
        .run_q       (run_q),
        .direct_en_q (direct_en_q)
    );

    always_comb clk_pin = (ref_clk & direct_en_q) | (run_q & ph_q);
endmodule

// File: rtl/clkout_gen_chk.sv
module clkout_gen_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [DIV_W-1:0] cnt_q,
    input logic [DIV_W-1:0] lim_q,
    input logic             ph_q,
    input logic             run_q
);
    // R3: counter stays below the active half-period length
    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        (lim_q != '0) |-> (cnt_q < lim_q));

    // R3: the phase only flips at the end of a half-period
    a_r3_toggle_at_wrap: assert property (@(posedge clk) disable iff (rst)
        ((lim_q != '0) && (cnt_q != DIV_W'(lim_q - 1'b1))) |=> $stable(ph_q));

    // R2: direct mode carries no divided phase
    a_r2_direct_no_phase: assert property (@(posedge clk) disable iff (rst)
        (lim_q == '0) |-> !ph_q);

    // R7: the half-period length is reloaded only at a boundary
    a_r7_reload_on_wrap: assert property (@(posedge clk) disable iff (rst)
        !$stable(lim_q) |-> (cnt_q == '0));

    // R6: the clock starts in a low phase
    a_r6_start_low: assert property (@(posedge clk) disable iff (rst)
        $rose(run_q) |-> !ph_q);

    // R5: the clock stops in a low phase
    a_r5_stop_low: assert property (@(posedge clk) disable iff (rst)
        $fell(run_q) |-> !ph_q);
endmodule

bind clkout_gen clkout_gen_chk #(.DIV_W(DIV_W)) i_chk (
    .clk   (ref_clk),
    .rst   (rst),
    .cnt_q (cnt_q),
    .lim_q (lim_q),
    .ph_q  (ph_q),
    .run_q (run_q)
);

// File: tb/test_clkout_gen.sv
`timescale 1ns/1ps
module test_clkout_gen;
    logic       ref_clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] div_setting = 8'd0;
    logic       host_configured = 1'b0;
    logic       host_suspended = 1'b0;
    logic       clk_pin;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    bit  cur;

    clkout_gen #(.DIV_W(8)) i_clkout_gen (
        .ref_clk(ref_clk), .rst(rst), .div_setting(div_setting),
        .host_configured(host_configured), .host_suspended(host_suspended),
        .clk_pin(clk_pin)
    );

    always #2 ref_clk = ~ref_clk;

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // sample once per cycle, in the high phase of the reference
    task automatic next_sample();
        @(posedge ref_clk); #1.5;
        cur = clk_pin;
    endtask

    // cur holds the first sample of a run at level lvl
    task automatic meas_run(input bit lvl, output int len);
        len = 1;
        next_sample();
        while (cur == lvl && len < 700) begin
            len++;
            next_sample();
        end
    endtask

    task automatic hold_low(input string req, input int cycles);
        int bad = 0;
        for (int i = 0; i < cycles; i++) begin
            next_sample();
            if (cur) bad++;
        end
        check(req, bad, 0);
    endtask

    task automatic run_div(input int n, input bit use_susp);
        int len;
        int wait_c;
        host_configured = 1'b0; host_suspended = use_susp;
        div_setting = 8'(n);
        hold_low("R4 idle low", 2 * n + 4);
        host_configured = 1'b1; host_suspended = 1'b0;
        wait_c = 0;
        do begin
            next_sample(); wait_c++;
        end while (!cur && wait_c < 3 * n + 3);
        check("R6 start latency", int'(cur), 1);
        meas_run(1'b1, len); check("R6 first pulse", len, n);
        for (int k = 0; k < 3; k++) begin
            meas_run(1'b0, len); check("R3 low phase", len, n);
            meas_run(1'b1, len); check("R3 high phase", len, n);
        end
        meas_run(1'b0, len); check("R3 low phase", len, n);
        if (use_susp) host_suspended = 1'b1; else host_configured = 1'b0;
        meas_run(1'b1, len); check("R5 last pulse", len, n);
        hold_low("R4 stays low", 4 * n + 4);
    endtask

    initial begin
        int len;
        int bad;
        host_configured = 1'b1;
        repeat (3) @(posedge ref_clk);
        #1.5; check("R1 reset high phase", int'(clk_pin), 0);
        @(negedge ref_clk); #1.5; check("R1 reset low phase", int'(clk_pin), 0);
        @(posedge ref_clk); #1.5; rst = 1'b0;

        // R2 direct mode
        repeat (4) @(posedge ref_clk);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(posedge ref_clk); #1.5; if (clk_pin !== 1'b1) bad++;
            @(negedge ref_clk); #1.5; if (clk_pin !== 1'b0) bad++;
        end
        check("R2 direct follows reference", bad, 0);
        @(posedge ref_clk); #1.5; host_suspended = 1'b1;
        repeat (3) @(posedge ref_clk);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(posedge ref_clk); #1.5; if (clk_pin !== 1'b0) bad++;
            @(negedge ref_clk); #1.5; if (clk_pin !== 1'b0) bad++;
        end
        check("R4 direct disabled low", bad, 0);
        @(posedge ref_clk); #1.5;

        for (int n = 1; n <= 16; n++) run_div(n, n[0]);
        run_div(255, 1'b1);

        // R7 setting change during a high phase: 3 -> 5
        host_configured = 1'b1; host_suspended = 1'b0; div_setting = 8'd3;
        do next_sample(); while (!cur);
        meas_run(1'b1, len);
        do next_sample(); while (!cur);
        div_setting = 8'd5;
        meas_run(1'b1, len); check("R7 old length kept", len, 3);
        meas_run(1'b0, len); check("R7 new low length", len, 5);
        meas_run(1'b1, len); check("R7 new high length", len, 5);
        // R7 change during a low phase: 5 -> 2
        div_setting = 8'd2;
        meas_run(1'b0, len); check("R7 old low length", len, 5);
        meas_run(1'b1, len); check("R7 new high length", len, 2);
        meas_run(1'b0, len); check("R7 new low length", len, 2);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule